// File: doc/BRIEF.md
# Capture/Compare Timer with Output Match Actions

This block is a 16-bit up-counter with two working modes. In input-capture mode, a chosen edge on a capture source copies the running count into a capture register and raises an interrupt request. The capture source is either an already-filtered external level or an internal slow oscillator tick divided by 128. In output-compare mode, two compare registers are checked against the count on every count tick. Each match applies its own action to a single output pin: hold, invert, drive low or drive high. A match on compare 1 can optionally clear the counter, which gives a programmable period.

The count tick comes from one of four sources: the undivided clock, a free-running divide-by-8 or divide-by-32 prescaler tap, or an external fast clock-enable. Software reaches the block through a single-cycle synchronous write port and a combinational read port. Fields that shape the timing can be changed only while counting is stopped.

Top module: `cc_timer`

## Requirements
- R1: After an asynchronous active-low reset, every register reads zero, `cmp_out` is low and `irq` is low. The register addresses are: 0 = control A, 1 = control B, 2 = count (read only), 3 = compare 0, 4 = compare 1, 5 = capture (read only). Unmapped addresses read zero.
- R2: Control A bit 0 is the run bit. While it is 1, the count rises by one on each selected tick and wraps from FFFFh to 0000h. While it is 0, the count holds.
- R3: Control A bits [2:1] select the tick: 00 every clock, 01 one clock in 8 from a free-running prescaler, 10 one clock in 32, 11 the `fast_tick` input.
- R4: When control B bit 1 (mode) is 0 and the block is running, a capture edge copies the count held before that clock edge into the capture register. Control A bits [4:3] choose the edge: 00 rising, 01 falling, 10 both, 11 none.
- R5: Control A bit 5 switches the capture source from `cap_in` to an internal level that toggles every 64 `slow_tick` pulses (a period of 128 pulses).
- R6: When mode is 1, a compare match occurs on a tick whose pre-tick count equals the compare value. The match applies the channel's action to `cmp_out`. Compare 0 uses control B bits [3:2] and compare 1 uses bits [5:4]: 00 hold, 01 invert, 10 low, 11 high.
- R7: Control B bit 0 (clear) set to 1 makes a compare-1 match load the count with 0000h instead of incrementing it. Set to 0, the count runs free past the compare-1 value.
- R8: When both compares match on the same tick, only the compare-1 action is applied, even if that action is hold.
- R9: While the run bit is 1, a write leaves the mode bit, tick select, edge select and capture source bit unchanged. The run bit itself is still written.
- R10: While mode is 0, the clear bit and both action fields read zero and `cmp_out` does not change.
- R11: `irq` pulses high for one cycle after each capture event or compare-match tick. It is low in the cycle after any cycle in which the block is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| cap_in | input | 1 | Filtered external capture level |
| fast_tick | input | 1 | Fast alternate count enable |
| slow_tick | input | 1 | Slow oscillator tick feeding the divide-by-128 |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The hardest case to reach from the ports is the 16-bit wrap, because the count can only be advanced by ticks and it cannot be written. The bench runs 65537 undivided ticks and expects a count of 1. The prescaled and fast-tick sources are checked over windows whose length is a whole multiple of the divisor, which makes the expected count independent of the prescaler phase. The slow capture source is checked the same way, by counting interrupt pulses over 256 cycles with both edges selected.

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int CNT_W     = 16,
  parameter int PRE_A_LOG = 3,
  parameter int PRE_B_LOG = 5,
  parameter int SLOW_LOG  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             cap_in,
  input  logic             fast_tick,
  input  logic             slow_tick,
  output logic             cmp_out,
  output logic             irq
);
  localparam logic [2:0] A_CTLA = 3'd0, A_CTLB = 3'd1, A_CNT = 3'd2,
                         A_CMP0 = 3'd3, A_CMP1 = 3'd4, A_CAP = 3'd5;

  logic             run, mode, capsel, clr1, src_q;
  logic [1:0]       src, pol, act0, act1;
  logic [CNT_W-1:0] count, cmp0, cmp1, cap;
  logic [PRE_B_LOG-1:0] pre;
  logic [SLOW_LOG-1:0]  slow_div;

  wire wr_a = bus_we && bus_addr == A_CTLA;
  wire wr_b = bus_we && bus_addr == A_CTLB;
  wire mode_nx = run ? mode : bus_wdata[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run <= 1'b0; src <= '0; pol <= '0; capsel <= 1'b0;
    end else if (wr_a) begin
      run <= bus_wdata[0];
      if (!run) begin
        src    <= bus_wdata[2:1];
        pol    <= bus_wdata[4:3];
        capsel <= bus_wdata[5];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= 1'b0; clr1 <= 1'b0; act0 <= '0; act1 <= '0;
    end else if (wr_b) begin
      mode <= mode_nx;
      clr1 <= mode_nx & bus_wdata[0];
      act0 <= mode_nx ? bus_wdata[3:2] : 2'b00;
      act1 <= mode_nx ? bus_wdata[5:4] : 2'b00;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp0 <= '0; cmp1 <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_CMP0) cmp0 <= bus_wdata;
      if (bus_addr == A_CMP1) cmp1 <= bus_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         slow_div <= '0;
    else if (slow_tick) slow_div <= slow_div + 1'b1;

  logic sel_tick;
  always_comb
    case (src)
      2'b00:   sel_tick = 1'b1;
      2'b01:   sel_tick = &pre[PRE_A_LOG-1:0];
      2'b10:   sel_tick = &pre;
      default: sel_tick = fast_tick;
    endcase

  wire tick = run & sel_tick;
  wire hit0 = tick & mode & (count == cmp0);
  wire hit1 = tick & mode & (count == cmp1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    count <= '0;
    else if (tick) count <= (hit1 & clr1) ? '0 : count + 1'b1;

  wire [1:0] act = hit1 ? act1 : act0;
  logic out_nx;
  always_comb begin
    out_nx = cmp_out;
    if (hit0 | hit1)
      case (act)
        2'b01:   out_nx = ~cmp_out;
        2'b10:   out_nx = 1'b0;
        2'b11:   out_nx = 1'b1;
        default: out_nx = cmp_out;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cmp_out <= 1'b0;
    else        cmp_out <= out_nx;

  wire lvl = capsel ? slow_div[SLOW_LOG-1] : cap_in;
  logic edge_hit;
  always_comb
    case (pol)
      2'b00:   edge_hit = lvl & ~src_q;
      2'b01:   edge_hit = ~lvl & src_q;
      2'b10:   edge_hit = lvl ^ src_q;
      default: edge_hit = 1'b0;
    endcase
  wire cap_hit = run & ~mode & edge_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      src_q <= 1'b0; cap <= '0; irq <= 1'b0;
    end else begin
      src_q <= lvl;
      if (cap_hit) cap <= count;
      irq <= cap_hit | hit0 | hit1;
    end

  always_comb
    case (bus_addr)
      A_CTLA:  bus_rdata = CNT_W'({capsel, pol, src, run});
      A_CTLB:  bus_rdata = CNT_W'({act1, act0, mode, clr1});
      A_CNT:   bus_rdata = count;
      A_CMP0:  bus_rdata = cmp0;
      A_CMP1:  bus_rdata = cmp1;
      A_CAP:   bus_rdata = cap;
      default: bus_rdata = '0;
    endcase
endmodule

module cc_timer_chk #(parameter int CNT_W = 16) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             mode,
  input logic             clr1,
  input logic [1:0]       src,
  input logic [1:0]       act0,
  input logic [1:0]       act1,
  input logic [CNT_W-1:0] count,
  input logic             cmp_out,
  input logic             irq
);
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mode && src == 2'b00) |=> count == CNT_W'($past(count) + 1'b1));
  // R9
  src_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(src) && $stable(mode));
  // R10
  cap_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> (!clr1 && act0 == 2'b00 && act1 == 2'b00));
  // R10
  cap_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |=> $stable(cmp_out));
  // R11
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq);
endmodule

bind cc_timer cc_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .clr1(clr1),
  .src(src), .act0(act0), .act1(act1), .count(count),
  .cmp_out(cmp_out), .irq(irq)
);

// File: tb/cc_timer_bench.sv
module cc_timer_bench;
  logic        clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        cap_in = 1'b0, fast_tick = 1'b0, slow_tick = 1'b1;
  logic        cmp_out, irq;
  int          n_chk = 0, n_bad = 0, irq_seen = 0, fph = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  cc_timer u_cc_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .fast_tick(fast_tick), .slow_tick(slow_tick), .cmp_out(cmp_out), .irq(irq)
  );

  always @(negedge clk) begin
    if (irq) irq_seen++;
    fph = (fph == 2) ? 0 : fph + 1;
    fast_tick = (fph == 2);
  end

  typedef struct packed {
    logic [1:0]  a0;
    logic [1:0]  a1;
    logic        clr;
    logic [15:0] c0;
    logic [15:0] c1;
    logic [16:0] n;
    logic        eo;
    logic [15:0] ec;
    logic [3:0]  ei;
  } vec_t;

  localparam vec_t VT [7] = '{
    '{2'b01, 2'b00, 1'b0, 16'd3,     16'd100, 17'd10, 1'b1, 16'd10, 4'd1},
    '{2'b11, 2'b10, 1'b0, 16'd2,     16'd5,   17'd10, 1'b0, 16'd10, 4'd2},
    '{2'b11, 2'b10, 1'b0, 16'd2,     16'd5,   17'd4,  1'b1, 16'd4,  4'd1},
    '{2'b00, 2'b01, 1'b1, 16'hFFFF,  16'd4,   17'd7,  1'b1, 16'd2,  4'd1},
    '{2'b11, 2'b10, 1'b0, 16'd3,     16'd3,   17'd6,  1'b0, 16'd6,  4'd1},
    '{2'b10, 2'b11, 1'b0, 16'd3,     16'd3,   17'd6,  1'b1, 16'd6,  4'd1},
    '{2'b01, 2'b00, 1'b1, 16'd5,     16'd5,   17'd6,  1'b0, 16'd0,  4'd1}
  };
  vec_t v;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    irq_seen = 0;
  endtask

  task automatic run_edges(input logic [15:0] ctl, input int n);
    wr(3'd0, ctl);
    repeat (n - 1) @(posedge clk);
    wr(3'd0, {ctl[15:1], 1'b0});
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: all requirements, got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), rv);
      check("R1 register reset", {16'd0, rv}, 32'd0);
    end
    check("R1 cmp_out reset", {31'd0, cmp_out}, 32'd0);
    check("R1 irq reset", {31'd0, irq}, 32'd0);

    // R6 R7 R8 R11 compare vectors
    for (int i = 0; i < 7; i++) begin
      v = VT[i];
      do_reset();
      wr(3'd3, v.c0);
      wr(3'd4, v.c1);
      wr(3'd1, {10'd0, v.a1, v.a0, 1'b1, v.clr});
      run_edges(16'h0001, int'(v.n));
      rd(3'd2, rv);
      check($sformatf("R7 count vec %0d", i), {16'd0, rv}, {16'd0, v.ec});
      check($sformatf("R6 R8 cmp_out vec %0d", i), {31'd0, cmp_out}, {31'd0, v.eo});
      check($sformatf("R11 irq pulses vec %0d", i), irq_seen, {28'd0, v.ei});
    end

    // R2 wrap and hold
    do_reset();
    run_edges(16'h0001, 65537);
    rd(3'd2, rv);
    check("R2 wrap count", {16'd0, rv}, 32'd1);
    repeat (5) @(posedge clk);
    rd(3'd2, rv);
    check("R2 stopped hold", {16'd0, rv}, 32'd1);

    // R3 tick sources
    do_reset();
    run_edges(16'h0003, 64);
    rd(3'd2, rv);
    check("R3 div8 source", {16'd0, rv}, 32'd8);
    do_reset();
    run_edges(16'h0005, 64);
    rd(3'd2, rv);
    check("R3 div32 source", {16'd0, rv}, 32'd2);
    do_reset();
    run_edges(16'h0007, 63);
    rd(3'd2, rv);
    check("R3 fast source", {16'd0, rv}, 32'd21);

    // R4 rising edge
    cap_in = 1'b0;
    do_reset();
    wr(3'd0, 16'h0001);
    repeat (9) @(posedge clk);
    @(negedge clk) cap_in = 1'b1;
    wr(3'd0, 16'h0000);
    @(posedge clk);
    rd(3'd5, rv);
    check("R4 rising capture", {16'd0, rv}, 32'd9);
    check("R4 rising irq", irq_seen, 1);

    // R4 falling edge
    cap_in = 1'b0;
    do_reset();
    wr(3'd0, 16'h0009);
    repeat (4) @(posedge clk);
    @(negedge clk) cap_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) cap_in = 1'b0;
    wr(3'd0, 16'h0000);
    @(posedge clk);
    rd(3'd5, rv);
    check("R4 falling capture", {16'd0, rv}, 32'd7);
    check("R4 falling irq", irq_seen, 1);

    // R4 both edges
    do_reset();
    wr(3'd0, 16'h0011);
    repeat (3) @(posedge clk);
    @(negedge clk) cap_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) cap_in = 1'b0;
    wr(3'd0, 16'h0000);
    @(posedge clk);
    rd(3'd5, rv);
    check("R4 both capture", {16'd0, rv}, 32'd5);
    check("R4 both irq", irq_seen, 2);

    // R4 illegal edge code
    do_reset();
    wr(3'd0, 16'h0019);
    repeat (3) @(posedge clk);
    @(negedge clk) cap_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) cap_in = 1'b0;
    wr(3'd0, 16'h0000);
    @(posedge clk);
    rd(3'd5, rv);
    check("R4 code 11 no capture", {16'd0, rv}, 32'd0);
    check("R4 code 11 no irq", irq_seen, 0);

    // R5 slow source, both edges over 256 cycles
    do_reset();
    wr(3'd0, 16'h0030);
    repeat (3) @(posedge clk);
    irq_seen = 0;
    run_edges(16'h0031, 256);
    check("R5 slow source edges", irq_seen, 4);

    // R9 locked fields while running
    do_reset();
    wr(3'd0, 16'h0001);
    wr(3'd0, 16'h002D);
    rd(3'd0, rv);
    check("R9 control A locked", {16'd0, rv}, 32'h0001);
    wr(3'd1, 16'h0002);
    rd(3'd1, rv);
    check("R9 mode locked", {16'd0, rv}, 32'h0000);
    wr(3'd0, 16'h0000);
    rd(3'd0, rv);
    check("R9 run bit still writable", {16'd0, rv}, 32'h0000);

    // R10 capture-mode fields forced to zero
    wr(3'd1, 16'h003D);
    rd(3'd1, rv);
    check("R10 fields zero in capture mode", {16'd0, rv}, 32'h0000);
    wr(3'd1, 16'h003F);
    rd(3'd1, rv);
    check("R10 fields kept in compare mode", {16'd0, rv}, 32'h003F);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule